// File: doc/BRIEF.md
# Interleaved Bank Conflict Recirculator

This block sits in front of an interleaved memory built from independent banks. The bank number is taken from the low address bits. Once a bank is started it stays busy for a fixed number of clock cycles. Each cycle the block decides which single request may start a bank.

A new request whose bank is idle, and which no earlier request is still waiting for, starts that bank in the same cycle. A request whose bank is occupied is parked in a short ring of registers. The ring carries it round and presents it again each time it returns. A returning request outranks a new one. A new request is refused at once if its address falls outside an inclusive window set by two inputs. A new request is held back if it would put a read and a write to the same address into flight together, so the two cannot be reordered.

The requester keeps `req_valid` and its fields steady until `req_ready` is seen high at a clock edge. The memory side starts the bank named by `issue_addr` in every cycle where `issue_valid` is high.

Top module: `bank_recirc_arbiter`

## Requirements
- R1: Out of reset the ring is empty and every bank is idle, so no issue occurs until a request arrives.
- R2: The bank of an address is its low BANK_BITS bits (bits 4:0 by default). Two issues to the same bank are at least BANK_CYC cycles apart (10 by default).
- R3: A valid, in-window request issues in its own cycle, with `req_ready` high and `issue_from_loop` low, when four conditions all hold: its bank is idle, no ring entry is returning with an idle bank, no ring entry targets the same bank, and no order hazard exists.
- R4: An in-window request that cannot issue directly is accepted into the ring. It is then issued exactly once, with its own address and direction, after it has made a whole number of LOOP_STAGES-cycle trips (3 by default).
- R5: When the entry returning from the ring finds its bank still busy, it takes the ring's entry slot. During that cycle a new request that cannot issue directly sees `req_ready` low.
- R6: A returning entry whose bank is idle is always issued, with `issue_from_loop` high. A new request in the same cycle cannot issue and is parked instead.
- R7: Two back-to-back requests to the same bank are each issued within two bank cycles of their acceptance.
- R8: A request with an address below `lim_lo` or above `lim_hi` is refused: `req_reject` and `req_ready` are high in that cycle, and it is never issued. Addresses equal to either limit are accepted.
- R9: A new request whose address matches a ring entry of the opposite direction sees `req_ready` low until that entry has been issued. Per address, reads and writes are issued in the order they were accepted.
- R10: A new request whose bank is idle, but whose bank is targeted by an entry still in the ring, does not overtake that entry. It is parked instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_lo | input | ADDR_W | Lowest address accepted |
| lim_hi | input | ADDR_W | Highest address accepted |
| req_valid | input | 1 | New request present |
| req_addr | input | ADDR_W | Word address of the new request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ready | output | 1 | Request taken (issued, parked or refused) at this edge |
| req_reject | output | 1 | Request refused as out of window |
| issue_valid | output | 1 | A bank is started this cycle |
| issue_addr | output | ADDR_W | Address of the started access |
| issue_write | output | 1 | Direction of the started access |
| issue_from_loop | output | 1 | Started access came from the ring |

## Verification
Some properties are checked every cycle against the bank timers and the ring registers. These are: no issue to a busy bank, a bank turning busy right after issue, a returning entry with an idle bank always winning the issue slot, refusal of out-of-window requests, parking of every accepted request that was not issued, and stalling on an opposite-direction address match. Other behaviours appear only across whole scenarios, so only the bench can show them. These are the exact issue cycle after a number of ring trips, the two-bank-cycle service bound for back-to-back requests, non-overtaking of a waiting entry, the full ring blocking new entries until a slot frees, and per-address read/write order over long random traffic.

// File: rtl/bank_recirc_pkg.sv
`timescale 1ns/1ps
package bank_recirc_pkg;

   typedef enum logic [1:0] {
      SRC_IDLE  = 2'd0,
      SRC_RING  = 2'd1,
      SRC_FRESH = 2'd2
   } issue_src_e;

endpackage

// File: rtl/bank_busy_timers.sv
`timescale 1ns/1ps
module bank_busy_timers #(
   parameter int BANK_BITS = 5,
   parameter int BANK_CYC  = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [BANK_BITS-1:0] start_bank,
   output logic [(1<<BANK_BITS)-1:0] busy
);
   localparam int NBANK = 1 << BANK_BITS;
   localparam int CW    = $clog2(BANK_CYC);

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic [CW-1:0] remain;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            remain <= '0;
         end else if (start && (start_bank == BANK_BITS'(g))) begin
            remain <= CW'(BANK_CYC - 1);
         end else if (remain != '0) begin
            remain <= remain - 1'b1;
         end
      end
      assign busy[g] = (remain != '0);
   end

endmodule

// File: rtl/recirc_ring.sv
`timescale 1ns/1ps
module recirc_ring #(
   parameter int ADDR_W = 12,
   parameter int STAGES = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_v,
   input  logic [ADDR_W-1:0]             in_addr,
   input  logic                          in_wr,
   output logic [STAGES-1:0]             st_v,
   output logic [STAGES-1:0][ADDR_W-1:0] st_addr,
   output logic [STAGES-1:0]             st_wr
);

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic              nxt_v;
      logic [ADDR_W-1:0] nxt_addr;
      logic              nxt_wr;
      if (g == 0) begin : g_head
         assign nxt_v    = in_v;
         assign nxt_addr = in_addr;
         assign nxt_wr   = in_wr;
      end else begin : g_body
         assign nxt_v    = st_v[g-1];
         assign nxt_addr = st_addr[g-1];
         assign nxt_wr   = st_wr[g-1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_v[g]    <= 1'b0;
            st_addr[g] <= '0;
            st_wr[g]   <= 1'b0;
         end else begin
            st_v[g]    <= nxt_v;
            st_addr[g] <= nxt_v ? nxt_addr : '0;
            st_wr[g]   <= nxt_v & nxt_wr;
         end
      end
   end

endmodule

// File: rtl/order_guard.sv
`timescale 1ns/1ps
module order_guard #(
   parameter int ADDR_W  = 12,
   parameter int STAGES  = 3,
   parameter bit ANY_DIR = 1'b0
) (
   input  logic [ADDR_W-1:0]             new_addr,
   input  logic                          new_wr,
   input  logic [STAGES-1:0]             st_v,
   input  logic [STAGES-1:0][ADDR_W-1:0] st_addr,
   input  logic [STAGES-1:0]             st_wr,
   output logic                          clash
);
   logic [STAGES-1:0] hit;

   for (genvar g = 0; g < STAGES; g++) begin : g_cmp
      if (ANY_DIR) begin : g_any
         assign hit[g] = st_v[g] && (st_addr[g] == new_addr);
      end else begin : g_opp
         assign hit[g] = st_v[g] && (st_addr[g] == new_addr) && (st_wr[g] != new_wr);
      end
   end

   assign clash = |hit;

endmodule

// File: rtl/bank_recirc_arbiter.sv
`timescale 1ns/1ps
module bank_recirc_arbiter
   import bank_recirc_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int BANK_BITS   = 5,
   parameter int BANK_CYC    = 10,
   parameter int LOOP_STAGES = 3,
   parameter bit STRICT_SAME = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lim_lo,
   input  logic [ADDR_W-1:0] lim_hi,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic              req_ready,
   output logic              req_reject,
   output logic              issue_valid,
   output logic [ADDR_W-1:0] issue_addr,
   output logic              issue_write,
   output logic              issue_from_loop
);
   localparam int NBANK = 1 << BANK_BITS;
   localparam int LAST  = LOOP_STAGES - 1;

   if (BANK_BITS < 1 || BANK_BITS > ADDR_W) begin : g_bad_bits
      $error("BANK_BITS must lie in 1..ADDR_W");
   end
   if (BANK_CYC < 2) begin : g_bad_cyc
      $error("BANK_CYC must be at least 2");
   end
   if (LOOP_STAGES < 1 || LOOP_STAGES >= BANK_CYC) begin : g_bad_ring
      $error("LOOP_STAGES must be at least 1 and shorter than BANK_CYC");
   end

   logic [NBANK-1:0]                   bank_busy;
   logic [LOOP_STAGES-1:0]             lp_v;
   logic [LOOP_STAGES-1:0][ADDR_W-1:0] lp_addr;
   logic [LOOP_STAGES-1:0]             lp_wr;

   logic [BANK_BITS-1:0] new_bank;
   logic [BANK_BITS-1:0] ret_bank;
   logic in_win, clash, ring_wants;
   logic ret_go, ret_recirc, can_direct, fresh_go, fresh_park;
   logic push_v, push_wr;
   logic [ADDR_W-1:0] push_addr;
   issue_src_e src;

   assign new_bank = req_addr[BANK_BITS-1:0];
   assign ret_bank = lp_addr[LAST][BANK_BITS-1:0];
   assign in_win   = (req_addr >= lim_lo) && (req_addr <= lim_hi);

   always_comb begin
      ring_wants = 1'b0;
      for (int i = 0; i < LOOP_STAGES; i++) begin
         if (lp_v[i] && (lp_addr[i][BANK_BITS-1:0] == new_bank)) ring_wants = 1'b1;
      end
   end

   order_guard #(
      .ADDR_W (ADDR_W),
      .STAGES (LOOP_STAGES),
      .ANY_DIR(STRICT_SAME)
   ) u_guard (
      .new_addr(req_addr),
      .new_wr  (req_write),
      .st_v    (lp_v),
      .st_addr (lp_addr),
      .st_wr   (lp_wr),
      .clash   (clash)
   );

   assign ret_go     = lp_v[LAST] && !bank_busy[ret_bank];
   assign ret_recirc = lp_v[LAST] && bank_busy[ret_bank];
   assign can_direct = !ret_go && !bank_busy[new_bank] && !ring_wants;
   assign fresh_go   = req_valid && in_win && !clash && can_direct;
   assign fresh_park = req_valid && in_win && !clash && !can_direct && !ret_recirc;

   assign req_ready  = !in_win || (!clash && (can_direct || !ret_recirc));
   assign req_reject = req_valid && !in_win;

   always_comb begin
      if (ret_go)        src = SRC_RING;
      else if (fresh_go) src = SRC_FRESH;
      else               src = SRC_IDLE;
   end

   always_comb begin
      issue_valid     = 1'b0;
      issue_addr      = '0;
      issue_write     = 1'b0;
      issue_from_loop = 1'b0;
      unique case (src)
         SRC_RING: begin
            issue_valid     = 1'b1;
            issue_addr      = lp_addr[LAST];
            issue_write     = lp_wr[LAST];
            issue_from_loop = 1'b1;
         end
         SRC_FRESH: begin
            issue_valid = 1'b1;
            issue_addr  = req_addr;
            issue_write = req_write;
         end
         default: ;
      endcase
   end

   always_comb begin
      push_v    = ret_recirc | fresh_park;
      push_addr = ret_recirc ? lp_addr[LAST] : req_addr;
      push_wr   = ret_recirc ? lp_wr[LAST]   : req_write;
   end

   bank_busy_timers #(
      .BANK_BITS(BANK_BITS),
      .BANK_CYC (BANK_CYC)
   ) u_timers (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (issue_valid),
      .start_bank(issue_addr[BANK_BITS-1:0]),
      .busy      (bank_busy)
   );

   recirc_ring #(
      .ADDR_W(ADDR_W),
      .STAGES(LOOP_STAGES)
   ) u_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_v   (push_v),
      .in_addr(push_addr),
      .in_wr  (push_wr),
      .st_v   (lp_v),
      .st_addr(lp_addr),
      .st_wr  (lp_wr)
   );

endmodule

// File: rtl/bank_recirc_checker.sv
`timescale 1ns/1ps
module bank_recirc_checker #(
   parameter int ADDR_W      = 12,
   parameter int BANK_BITS   = 5,
   parameter int LOOP_STAGES = 3
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic [ADDR_W-1:0]                  lim_lo,
   input logic [ADDR_W-1:0]                  lim_hi,
   input logic                               req_valid,
   input logic [ADDR_W-1:0]                  req_addr,
   input logic                               req_write,
   input logic                               req_ready,
   input logic                               req_reject,
   input logic                               issue_valid,
   input logic [ADDR_W-1:0]                  issue_addr,
   input logic                               issue_from_loop,
   input logic [(1<<BANK_BITS)-1:0]          bank_busy,
   input logic [LOOP_STAGES-1:0]             st_v,
   input logic [LOOP_STAGES-1:0][ADDR_W-1:0] st_addr,
   input logic [LOOP_STAGES-1:0]             st_wr
);
   localparam int LAST = LOOP_STAGES - 1;

   logic [BANK_BITS-1:0] iss_bank;
   logic [BANK_BITS-1:0] tail_bank;
   logic                 fresh_issue;
   logic                 outside;
   logic                 opp_match;

   assign iss_bank    = issue_addr[BANK_BITS-1:0];
   assign tail_bank   = st_addr[LAST][BANK_BITS-1:0];
   assign fresh_issue = issue_valid && !issue_from_loop;
   assign outside     = (req_addr < lim_lo) || (req_addr > lim_hi);

   always_comb begin
      opp_match = 1'b0;
      for (int i = 0; i < LOOP_STAGES; i++) begin
         if (st_v[i] && st_addr[i] == req_addr && st_wr[i] != req_write) opp_match = 1'b1;
      end
   end

   p_free_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !bank_busy[iss_bank]);

   p_busy_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |=> bank_busy[$past(iss_bank)]);

   p_ring_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_v[LAST] && !bank_busy[tail_bank]) |->
         (issue_valid && issue_from_loop && issue_addr == st_addr[LAST]));

   p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && outside) |-> (req_reject && req_ready && !fresh_issue));

   p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_reject && !fresh_issue) |=>
         (st_v[0] && st_addr[0] == $past(req_addr) && st_wr[0] == $past(req_write)));

   p_order_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !outside && opp_match) |-> !req_ready);

endmodule

bind bank_recirc_arbiter bank_recirc_checker #(
   .ADDR_W     (ADDR_W),
   .BANK_BITS  (BANK_BITS),
   .LOOP_STAGES(LOOP_STAGES)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .lim_lo         (lim_lo),
   .lim_hi         (lim_hi),
   .req_valid      (req_valid),
   .req_addr       (req_addr),
   .req_write      (req_write),
   .req_ready      (req_ready),
   .req_reject     (req_reject),
   .issue_valid    (issue_valid),
   .issue_addr     (issue_addr),
   .issue_from_loop(issue_from_loop),
   .bank_busy      (bank_busy),
   .st_v           (lp_v),
   .st_addr        (lp_addr),
   .st_wr          (lp_wr)
);

// File: tb/sim_bank_recirc_arbiter.sv
`timescale 1ns/1ps
module sim_bank_recirc_arbiter;
   localparam int AW  = 12;
   localparam int CYC = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] lim_lo = '0;
   logic [AW-1:0] lim_hi = 12'h0FF;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic          req_ready, req_reject, issue_valid, issue_write, issue_from_loop;
   logic [AW-1:0] issue_addr;

   int  n_chk = 0;
   int  n_bad = 0;
   int  cyc = 0;
   bit  done = 1'b0;
   int  last_bank [32];
   int  issue_cyc [256];
   bit  dq [256][$];

   always #2.5 clk = ~clk;

   bank_recirc_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .lim_lo(lim_lo), .lim_hi(lim_hi),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_ready(req_ready), .req_reject(req_reject),
      .issue_valid(issue_valid), .issue_addr(issue_addr),
      .issue_write(issue_write), .issue_from_loop(issue_from_loop)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // port monitor: scoreboard of accepted vs issued accesses
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (req_valid && req_reject)
            chk(req_ready && !(issue_valid && !issue_from_loop), "R8 refuse",
                {req_ready, issue_valid}, 2'b10);
         if (req_valid && req_ready && !req_reject)
            dq[req_addr[7:0]].push_back(req_write);
         if (issue_valid) begin
            automatic int b = int'(issue_addr[4:0]);
            automatic int a = int'(issue_addr[7:0]);
            if (last_bank[b] >= 0)
               chk(cyc - last_bank[b] >= CYC, "R2 bank spacing", cyc - last_bank[b], CYC);
            last_bank[b] = cyc;
            chk(issue_addr <= 12'h0FF, "R8 no out-of-window issue", issue_addr, 12'h0FF);
            if (dq[a].size() == 0) begin
               chk(1'b0, "R4 issue without acceptance", issue_addr, 0);
            end else begin
               chk(dq[a][0] == issue_write, "R9 per-address order", issue_write, dq[a][0]);
               void'(dq[a].pop_front());
            end
            issue_cyc[a] = cyc;
         end
      end
   end

   task automatic put(input logic [AW-1:0] a, input bit w);
      @(posedge clk); #1;
      req_valid = 1'b1; req_addr = a; req_write = w;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         req_valid = 1'b0;
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int t;
      for (int i = 0; i < 32; i++) last_bank[i] = -1;
      for (int i = 0; i < 256; i++) issue_cyc[i] = -1;
      void'($urandom(32'd4242));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: idle after reset
      @(posedge clk); #3;
      chk(!issue_valid && !req_reject, "R1 reset idle", issue_valid, 0);
      idle(2);

      // R3, R4, R6, R7: direct issue, parked retry, ring priority
      put(12'h005, 1'b0); t = cyc; #2;
      chk(issue_valid && issue_addr == 12'h005 && !issue_from_loop, "R3 direct issue", issue_addr, 12'h005);
      chk(req_ready, "R3 ready", req_ready, 1);
      put(12'h025, 1'b1); #2;
      chk(req_ready && !issue_valid, "R4 parked", {req_ready, issue_valid}, 2'b10);
      idle(8);
      put(12'h007, 1'b0); #2;
      chk(issue_valid && issue_from_loop && issue_addr == 12'h025, "R6 ring wins", issue_addr, 12'h025);
      chk(req_ready, "R6 new parked", req_ready, 1);
      idle(20);
      chk(issue_cyc[8'h25] == t + 10, "R7 back-to-back issue cycle", issue_cyc[8'h25] - t, 10);
      chk(issue_cyc[8'h07] == t + 13, "R6 loser issue cycle", issue_cyc[8'h07] - t, 13);

      // R10: no overtaking of a waiting ring entry
      put(12'h009, 1'b0); t = cyc;
      idle(1);
      put(12'h029, 1'b0);
      idle(7);
      put(12'h049, 1'b0); #2;
      chk(!issue_valid && req_ready, "R10 parked not overtaking", {issue_valid, req_ready}, 2'b01);
      idle(30);
      chk(issue_cyc[8'h29] == t + 11, "R10 waiting entry first", issue_cyc[8'h29] - t, 11);
      chk(issue_cyc[8'h49] == t + 22, "R7 second within two bank cycles", issue_cyc[8'h49] - t, 22);

      // R9: opposite-direction hazard stall
      put(12'h00C, 1'b1); t = cyc;
      put(12'h00C, 1'b0); #2;
      chk(req_ready && !issue_valid, "R9 read parked", req_ready, 1);
      put(12'h00C, 1'b1); #2;
      chk(!req_ready, "R9 write stalled", req_ready, 0);
      for (int k = 3; k <= 11; k++) begin
         @(posedge clk); #3;
         chk(req_ready == (k == 11), "R9 stall window", req_ready, (k == 11));
         if (k == 10)
            chk(issue_valid && issue_addr == 12'h00C && !issue_write, "R9 read first", issue_write, 0);
      end
      idle(25);
      chk(issue_cyc[8'h0C] == t + 20, "R9 write after read", issue_cyc[8'h0C] - t, 20);

      // R5: ring entry slot taken by recirculating entry
      put(12'h003, 1'b0); t = cyc;
      put(12'h023, 1'b0);
      put(12'h043, 1'b0);
      put(12'h063, 1'b0); #2;
      chk(req_ready, "R5 third entry accepted", req_ready, 1);
      put(12'h083, 1'b0); #2;
      chk(!req_ready, "R5 slot blocked", req_ready, 0);
      for (int k = 5; k <= 10; k++) begin
         @(posedge clk); #3;
         chk(req_ready == (k == 10), "R5 slot frees", req_ready, (k == 10));
      end
      idle(60);
      chk(issue_cyc[8'h43] == t + 20, "R5 second entry", issue_cyc[8'h43] - t, 20);
      chk(issue_cyc[8'h83] == t + 40, "R5 blocked request", issue_cyc[8'h83] - t, 40);

      // R8: window edges
      lim_lo = 12'h010;
      put(12'h00F, 1'b1); #2;
      chk(req_reject && req_ready && !issue_valid, "R8 below window", {req_reject, issue_valid}, 2'b10);
      put(12'h100, 1'b0); #2;
      chk(req_reject && req_ready && !issue_valid, "R8 above window", {req_reject, issue_valid}, 2'b10);
      put(12'h010, 1'b0); #2;
      chk(!req_reject && issue_valid && issue_addr == 12'h010, "R8 low edge accepted", issue_addr, 12'h010);
      put(12'h0FF, 1'b1); #2;
      chk(!req_reject && issue_valid && issue_addr == 12'h0FF, "R8 high edge accepted", issue_addr, 12'h0FF);
      idle(15);
      lim_lo = 12'h000;

      // random traffic (R2, R4, R8, R9 via monitor)
      for (int i = 0; i < 3000; i++) begin
         if ($urandom % 10 < 4) begin
            idle(1);
         end else begin
            automatic logic [AW-1:0] a = ($urandom % 8 == 0) ?
               AW'(12'h100 + ($urandom % 256)) : AW'($urandom % 64);
            put(a, 1'($urandom % 2)); #2;
            while (!req_ready) begin
               @(posedge clk); #3;
            end
         end
      end
      idle(200);
      begin
         automatic int left = 0;
         for (int i = 0; i < 256; i++) left += dq[i].size();
         chk(left == 0, "R4 every accepted request issued", left, 0);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule